// File: doc/BRIEF.md
# Two-Wire Bus Activity Watchdog

The block supervises a host by watching the clock and data lines of a two-wire serial bus. The host proves it is alive by putting a complete start/stop pair on the bus. A start condition is data falling while the clock is high. A stop condition is data rising while the clock is high. Each such pair clears the timeout counter. The counter advances on a millisecond tick. If it reaches the selected timeout before the next pair arrives, the block drives its active-low watchdog output low for a fixed pulse time and raises a one-cycle fault event for the fault register. It then starts counting again from zero with the same timeout.

A two-bit configuration code selects the timeout: a long, a medium or a short period, or disabled. The pulse time depends on the code. The long and medium periods use the long pulse and the short period uses the short pulse. A bus condition counts only if its level holds for a minimum number of clock cycles. This filter rejects glitches shorter than about one microsecond. The inputs are already synchronized. Open-drain pad logic lives outside the block.

Top module: `bus_watchdog`

## Requirements
- R1: A start condition is recognised only when SDA falls while SCL is high and then SDA stays low with SCL high for HOLD_CYC consecutive clock samples.
- R2: A stop condition is recognised only when SDA rises while SCL is high and then SDA stays high with SCL high for HOLD_CYC consecutive clock samples.
- R3: A recognised stop that follows a recognised start clears the timeout counter. A stop with no pending start has no effect.
- R4: Further starts after a pending start, such as repeated starts, leave the start pending and do not clear the counter. Only the next stop completes the pair.
- R5: A start or stop whose level holds for fewer than HOLD_CYC samples is ignored and cannot take part in a restart.
- R6: The timeout, counted in ms_tick pulses, is LONG_MS for code 00, MID_MS for code 01 and SHORT_MS for code 10.
- R7: On expiry, wdo_n goes low for PULSE_LONG_MS ticks under codes 00 and 01, or for PULSE_SHORT_MS ticks under code 10. Restarts that arrive during the pulse do not shorten it.
- R8: Each expiry raises wd_fail_evt for exactly one clock cycle, in the same cycle that wdo_n first goes low.
- R9: When the pulse ends, wdo_n returns high and the counter starts again from zero with the same timeout.
- R10: Code 11 (disabled) holds wdo_n high and keeps the counter at zero. This holds even when code 11 is selected during a pulse, in which case the pulse ends on the next clock.
- R11: Any change of the period code restarts the counter from zero and ends any pulse in progress.
- R12: After reset, wdo_n is high and wd_fail_evt is low. The first enabled code seen after reset starts a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| period_sel | input | 2 | Timeout code: 00 long, 01 medium, 10 short, 11 disabled |
| wdo_n | output | 1 | Active-low watchdog output |
| wd_fail_evt | output | 1 | One-cycle pulse per expiry, for the fault register |

## Verification
The bench drives timeouts with a steady stream of start/stop pairs and checks that no expiry occurs. It drives lone stops and strings of repeated starts and checks that the counter still expires. A design that restarted on any single condition would fail these checks. Glitches one or two samples short of the hold length are followed by a long clean stop. A design without the persistence filter would count that stop as completing a pair and suppress the expiry. Code changes in mid-count and a switch to disabled in mid-pulse check that a design does not carry stale count or stale pulse state across a reconfiguration. A cycle-accurate reference model compares both outputs on every clock, so an off-by-one in the period or pulse length shows up as a timing mismatch.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef logic [1:0] per_code_t;

    localparam per_code_t CODE_LONG  = 2'b00;
    localparam per_code_t CODE_MID   = 2'b01;
    localparam per_code_t CODE_SHORT = 2'b10;
    localparam per_code_t CODE_OFF   = 2'b11;

    typedef enum logic [1:0] {
        COND_NONE,
        COND_START,
        COND_STOP
    } cond_e;

    typedef enum logic [1:0] {
        WD_OFF,
        WD_RUN,
        WD_FIRE
    } wd_state_e;

    typedef struct packed {
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic int unsigned pick_period(per_code_t c, int unsigned l,
                                                int unsigned m, int unsigned s);
        case (c)
            CODE_LONG: return l;
            CODE_MID:  return m;
            default:   return s;
        endcase
    endfunction

    function automatic int unsigned pick_pulse(per_code_t c, int unsigned pl,
                                               int unsigned ps);
        return (c == CODE_SHORT) ? ps : pl;
    endfunction

endpackage

// File: rtl/bus_cond_det.sv
module bus_cond_det
    import wdg_pkg::*;
#(
    parameter int unsigned HOLD_CYC = 125
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    localparam int unsigned HW = $clog2(HOLD_CYC + 1);

    logic          sda_q;
    cond_e         cand;
    logic [HW-1:0] run;
    logic          fall, rise, level_ok;

    assign fall     = sda_q & ~sda_i & scl_i;
    assign rise     = ~sda_q & sda_i & scl_i;
    assign level_ok = scl_i & ((cand == COND_START) ? ~sda_i : sda_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sda_q <= 1'b1;
            cand  <= COND_NONE;
            run   <= '0;
            evt   <= '0;
        end else begin
            sda_q <= sda_i;
            evt   <= '0;
            if (fall || rise) begin
                if (HOLD_CYC <= 1) begin
                    evt.start <= fall;
                    evt.stop  <= rise;
                    cand      <= COND_NONE;
                end else begin
                    cand <= fall ? COND_START : COND_STOP;
                    run  <= HW'(1);
                end
            end else if (cand != COND_NONE) begin
                if (!level_ok) begin
                    cand <= COND_NONE;
                end else if (run == HW'(HOLD_CYC - 1)) begin
                    evt.start <= (cand == COND_START);
                    evt.stop  <= (cand == COND_STOP);
                    cand      <= COND_NONE;
                end else begin
                    run <= run + HW'(1);
                end
            end
        end
    end

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        evt.start |-> $past(scl_i && !sda_i)) else $error("start unqualified"); // R1
    AST_STOP_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
        evt.stop |-> $past(scl_i && sda_i)) else $error("stop unqualified"); // R2
    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(evt.start && evt.stop)) else $error("start and stop together"); // R5

endmodule

// File: rtl/bus_kick_pair.sv
module bus_kick_pair
    import wdg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt,
    output logic     kick
);
    logic armed;

    assign kick = evt.stop & armed;

    always_ff @(posedge clk) begin
        if (rst)            armed <= 1'b0;
        else if (evt.start) armed <= 1'b1;
        else if (evt.stop)  armed <= 1'b0;
    end

    AST_KICK_DISARMS: assert property (@(posedge clk) disable iff (rst)
        kick |=> !armed || $past(evt.start)) else $error("pair not consumed"); // R3
    AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> armed) else $error("start left unarmed"); // R4

endmodule

// File: rtl/wd_core.sv
module wd_core
    import wdg_pkg::*;
#(
    parameter int unsigned LONG_MS        = 1400,
    parameter int unsigned MID_MS         = 200,
    parameter int unsigned SHORT_MS       = 25,
    parameter int unsigned PULSE_LONG_MS  = 200,
    parameter int unsigned PULSE_SHORT_MS = 25
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  per_code_t code,
    input  logic      kick,
    output logic      wdo_n,
    output logic      fail_evt
);
    localparam int unsigned MAXP = (LONG_MS > MID_MS) ?
                                   ((LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS) :
                                   ((MID_MS > SHORT_MS) ? MID_MS : SHORT_MS);
    localparam int unsigned MAXQ = (PULSE_LONG_MS > PULSE_SHORT_MS) ? PULSE_LONG_MS : PULSE_SHORT_MS;
    localparam int unsigned MAXV = (MAXP > MAXQ) ? MAXP : MAXQ;
    localparam int unsigned CW   = $clog2(MAXV + 1);

    wd_state_e st;
    per_code_t code_q;
    logic [CW-1:0] cnt, lim, plim;

    always_comb begin
        lim  = CW'(pick_period(code, LONG_MS, MID_MS, SHORT_MS));
        plim = CW'(pick_pulse(code, PULSE_LONG_MS, PULSE_SHORT_MS));
    end

    assign wdo_n = (st != WD_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= WD_OFF;
            cnt      <= '0;
            code_q   <= CODE_OFF;
            fail_evt <= 1'b0;
        end else begin
            code_q   <= code;
            fail_evt <= 1'b0;
            if (code != code_q) begin
                cnt <= '0;
                st  <= (code == CODE_OFF) ? WD_OFF : WD_RUN;
            end else begin
                unique case (st)
                    WD_OFF: cnt <= '0;
                    WD_RUN: begin
                        if (kick) begin
                            cnt <= '0;
                        end else if (tick) begin
                            if (cnt == lim - CW'(1)) begin
                                st       <= WD_FIRE;
                                cnt      <= '0;
                                fail_evt <= 1'b1;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    WD_FIRE: begin
                        if (tick) begin
                            if (cnt == plim - CW'(1)) begin
                                st  <= WD_RUN;
                                cnt <= '0;
                            end else begin
                                cnt <= cnt + CW'(1);
                            end
                        end
                    end
                    default: st <= WD_OFF;
                endcase
            end
        end
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        (code_q == CODE_OFF && code == CODE_OFF) |=> wdo_n) else $error("active while disabled"); // R10
    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fail_evt |=> !fail_evt) else $error("event longer than one cycle"); // R8
    AST_FALL_HAS_EVT: assert property (@(posedge clk) disable iff (rst)
        $fell(wdo_n) |-> fail_evt) else $error("output fell without event"); // R8
    AST_CODE_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (code != code_q) |=> wdo_n) else $error("pulse survived code change"); // R11

endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
    import wdg_pkg::*;
#(
    parameter int unsigned HOLD_CYC       = 125,
    parameter int unsigned LONG_MS        = 1400,
    parameter int unsigned MID_MS         = 200,
    parameter int unsigned SHORT_MS       = 25,
    parameter int unsigned PULSE_LONG_MS  = 200,
    parameter int unsigned PULSE_SHORT_MS = 25
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       ms_tick,
    input  logic [1:0] period_sel,
    output logic       wdo_n,
    output logic       wd_fail_evt
);
    bus_evt_t evt;
    logic     kick;

    bus_cond_det #(.HOLD_CYC(HOLD_CYC)) u_det (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    bus_kick_pair u_pair (
        .clk(clk), .rst(rst), .evt(evt), .kick(kick)
    );

    wd_core #(
        .LONG_MS(LONG_MS), .MID_MS(MID_MS), .SHORT_MS(SHORT_MS),
        .PULSE_LONG_MS(PULSE_LONG_MS), .PULSE_SHORT_MS(PULSE_SHORT_MS)
    ) u_core (
        .clk(clk), .rst(rst), .tick(ms_tick), .code(period_sel), .kick(kick),
        .wdo_n(wdo_n), .fail_evt(wd_fail_evt)
    );

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (wdo_n && !wd_fail_evt)) else $error("not idle after reset"); // R12

endmodule

// File: tb/tb_bus_watchdog.sv
module tb_bus_watchdog;
    localparam int HOLD = 4;
    localparam int LNG = 14, MID = 8, SHT = 3, PLG = 5, PSH = 2;

    logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1, tick = 1'b0;
    logic [1:0] code = 2'b11;
    logic wdo_n, evt;

    int n_tests = 0, n_fail = 0, cyc = 0, evt_cnt = 0, tick_div = 0;
    string phase = "R12";

    always #4 clk = ~clk;

    bus_watchdog #(.HOLD_CYC(HOLD), .LONG_MS(LNG), .MID_MS(MID), .SHORT_MS(SHT),
                   .PULSE_LONG_MS(PLG), .PULSE_SHORT_MS(PSH)) dut (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda), .ms_tick(tick),
        .period_sel(code), .wdo_n(wdo_n), .wd_fail_evt(evt));

    // reference model state
    int  m_sda_prev = 1, m_cand = 0, m_run = 0, m_cnt = 0, m_st = 0, m_code_prev = 3;
    bit  m_startp = 0, m_stopp = 0, m_armed = 0, m_evt = 0;

    always @(posedge clk) begin
        bit kick_now, s_new, p_new;
        int lim, plim;
        if (rst) begin
            m_sda_prev = 1; m_cand = 0; m_run = 0; m_startp = 0; m_stopp = 0;
            m_armed = 0; m_cnt = 0; m_st = 0; m_code_prev = 3; m_evt = 0;
        end else begin
            kick_now = m_stopp && m_armed;
            lim  = (code == 0) ? LNG : (code == 1) ? MID : SHT;
            plim = (code == 2) ? PSH : PLG;
            m_evt = 0;
            if (int'(code) != m_code_prev) begin
                m_cnt = 0; m_st = (code == 3) ? 0 : 1;
            end else if (m_st == 0) begin
                m_cnt = 0;
            end else if (m_st == 1) begin
                if (kick_now) m_cnt = 0;
                else if (tick) begin
                    m_cnt++;
                    if (m_cnt == lim) begin m_st = 2; m_cnt = 0; m_evt = 1; end
                end
            end else if (tick) begin
                m_cnt++;
                if (m_cnt == plim) begin m_st = 1; m_cnt = 0; end
            end
            m_code_prev = int'(code);
            if (m_startp) m_armed = 1;
            else if (m_stopp) m_armed = 0;
            s_new = 0; p_new = 0;
            if (scl && m_sda_prev == 1 && !sda) begin m_cand = 1; m_run = 1; end
            else if (scl && m_sda_prev == 0 && sda) begin m_cand = 2; m_run = 1; end
            else if (m_cand != 0) begin
                if (!(scl && (m_cand == 1 ? !sda : sda))) m_cand = 0;
                else begin
                    m_run++;
                    if (m_run == HOLD) begin
                        s_new = (m_cand == 1); p_new = (m_cand == 2); m_cand = 0;
                    end
                end
            end
            m_startp = s_new; m_stopp = p_new;
            m_sda_prev = int'(sda);
        end
    end

    task automatic chk(input logic got, input logic exp, input string req);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, exp, cyc);
        end
    endtask

    task automatic chk_int(input int got, input int exp, input string req, input bit ge);
        n_tests++;
        if (ge ? (got < exp) : (got != exp)) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %s%0d", req, got, ge ? ">=" : "", exp);
        end
    endtask

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            chk(wdo_n, !(m_st == 2), {phase, " wdo_n"});
            chk(evt, m_evt, {phase, " fail event"});
            if (evt) evt_cnt++;
        end
        tick_div = (tick_div + 1) % 2;
        tick = (tick_div == 0);
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run hung");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input int hold); // from idle SCL=1 SDA=1
        sda = 1'b0; wait_cyc(hold); scl = 1'b0; wait_cyc(1);
    endtask

    task automatic do_stop(input int hold);  // from SCL=0
        sda = 1'b0; wait_cyc(1); scl = 1'b1; wait_cyc(1); sda = 1'b1; wait_cyc(hold);
    endtask

    task automatic do_rep_start(input int hold); // from SCL=0
        sda = 1'b1; wait_cyc(1); scl = 1'b1; wait_cyc(1); do_start(hold);
    endtask

    initial begin
        wait_cyc(3);
        chk(wdo_n, 1'b1, "R12 reset wdo_n");
        chk(evt, 1'b0, "R12 reset event");
        rst = 1'b0;
        wait_cyc(20);
        chk_int(evt_cnt, 0, "R10 disabled no expiry", 0);
        chk(wdo_n, 1'b1, "R10 disabled output high");

        phase = "R6/R7/R9 short"; evt_cnt = 0; code = 2'b10;
        wait_cyc(60);
        chk_int(evt_cnt, 4, "R9 repeated short expiries", 1);

        phase = "R3 kicked"; code = 2'b01; evt_cnt = 0;
        for (int i = 0; i < 8; i++) begin do_start(HOLD); do_stop(HOLD); end
        chk_int(evt_cnt, 0, "R3 pairs keep watchdog quiet", 0);

        phase = "R3 stop only"; evt_cnt = 0;
        for (int i = 0; i < 8; i++) begin scl = 1'b0; wait_cyc(1); do_stop(HOLD); end
        chk_int(evt_cnt, 1, "R3 lone stops do not restart", 1);

        phase = "R4 repeated start"; wait_cyc(30); evt_cnt = 0;
        do_start(HOLD);
        for (int i = 0; i < 6; i++) do_rep_start(HOLD);
        chk_int(evt_cnt, 1, "R4 repeated starts do not restart", 1);
        do_stop(HOLD);

        phase = "R5 glitch"; wait_cyc(30); evt_cnt = 0;
        for (int i = 0; i < 8; i++) begin
            do_start(HOLD - 1);
            do_stop(HOLD + 2);
        end
        chk_int(evt_cnt, 1, "R5 short start ignored", 1);

        phase = "R6/R7 long"; evt_cnt = 0; code = 2'b00;
        wait_cyc(2 * (LNG + PLG) + 6);
        chk_int(evt_cnt, 1, "R6 long period expiry", 1);

        phase = "R11 code change"; code = 2'b01;
        wait_cyc(2 * MID - 4);
        code = 2'b00; evt_cnt = 0;
        wait_cyc(8);
        chk_int(evt_cnt, 0, "R11 restart on code change", 0);

        phase = "R10 disable in pulse"; code = 2'b10;
        while (wdo_n) @(negedge clk);
        code = 2'b11;
        wait_cyc(1);
        chk(wdo_n, 1'b1, "R10 disable ends pulse");
        evt_cnt = 0; wait_cyc(40);
        chk_int(evt_cnt, 0, "R10 disabled stays quiet", 0);

        phase = "R12 re-enable"; code = 2'b10; wait_cyc(30);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule